// File: doc/BRIEF.md
# Strap-Selected Boot Header Parser

At power-up this block decides where a system boots from. It samples a three-bit strap once, in the first clock after reset is released. A strap of zero asks for a serial (UART) boot, and flash is never touched. Any other strap value selects flash boot and also acts as an index into a table of image descriptors.

For flash boot, the block reads a header from a memory-mapped flash window through a simple request/acknowledge read port. It first checks a fixed signature word. It then collects:

- the image destination address;
- the source and size pair chosen by the strap;
- a trailing word that carries a 16-bit mask and a 16-bit version.

It hands these fields to a downstream copy engine with a one-cycle valid strobe. If the signature is wrong, the block stops reading. It blinks a fault LED a fixed number of times and then raises a hibernate request, which it holds. Descrambling, copying and starting the image are handled elsewhere.

Top module: `boot_hdr_parse`

## Requirements
- R1: While `rst_n` is low, `rd_req_o`, `uart_boot_o`, `hdr_valid_o`, `led_o` and `hib_o` are all low.
- R2: A strap of 3'b000 raises `uart_boot_o` from the first clock after reset release and holds it there. `rd_req_o` is never asserted in this case.
- R3: The strap is latched once, in the first clock after reset release. Later strap changes have no effect on the addresses read or on the reported fields.
- R4: The word read at byte offset 0x00 must equal 32'h41524348. On a mismatch no further read is issued, `hdr_valid_o` never rises, and the fault path starts.
- R5: For a strap n in 1..7, the reads happen at `FLASH_BASE` plus these offsets, in this order: 0x00, 0x04, 8*n, 8*n+4, then 0xFC.
- R6: `rd_req_o` stays high with `rd_addr_o` unchanged until a cycle with `rd_ack_i` high. Data is taken from `rd_data_i` in that cycle.
- R7: `hdr_valid_o` is high for exactly one cycle, the cycle after the acknowledge of the last read. In that cycle the outputs are as follows: `dest_o` is the word at 0x04, `src_o` is the word at 8*n, and `len_o` is the word at 8*n+4.
- R8: `mask_o` is bits [31:16] of the big-endian word at 0xFC, and `ver_o` is bits [15:0] of that word.
- R9: On the fault path, `led_o` is high for `BLINK_HALF` cycles and then low for `BLINK_HALF` cycles, repeated `BLINK_COUNT` times. The first high cycle is the one after the failing acknowledge. `hib_o` rises exactly one cycle after the last low half ends. From then on `hib_o` stays high and `led_o` stays low.
- R10: At most one of `uart_boot_o`, `hdr_valid_o`, `hib_o` and `rd_req_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_i | input | 3 | Boot strap: zero means serial boot, otherwise descriptor index |
| rd_req_o | output | 1 | Flash read request |
| rd_addr_o | output | ADDR_W | Flash byte address of the current read |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 32 | Big-endian read data word |
| uart_boot_o | output | 1 | Serial boot requested (level) |
| hdr_valid_o | output | 1 | One-cycle strobe: descriptor fields valid |
| dest_o | output | 32 | Image destination address |
| src_o | output | 32 | Selected image source address |
| len_o | output | 32 | Selected image size |
| mask_o | output | 16 | Header mask value |
| ver_o | output | 16 | Header version value |
| led_o | output | 1 | Fault LED |
| hib_o | output | 1 | Hibernate request (level) |

## Verification
Each result has a fixed cycle relative to its stimulus:

- `uart_boot_o` is due one cycle after reset release.
- Each read's data is consumed in its acknowledge cycle. The next request address appears in the following cycle.
- `hdr_valid_o` comes exactly one cycle after the fifth acknowledge.
- On a failing signature, the first LED-high cycle is one cycle after the acknowledge. `hib_o` follows 2*BLINK_COUNT*BLINK_HALF+1 cycles later.

The bench samples at the falling edge and keeps a cycle index for every acknowledge, LED edge and strobe. It checks each result against the index at which it is due, not just its eventual value. It also checks that the request is held with a steady address across stall cycles.

// File: rtl/boot_hdr_pkg.sv
package boot_hdr_pkg;

  localparam logic [31:0] HDR_MAGIC = 32'h4152_4348;

  typedef enum logic [2:0] {
    ST_START, ST_FETCH, ST_ANNOUNCE, ST_SERIAL, ST_HANDOFF, ST_BLINK, ST_SLEEP
  } boot_st_e;

  // Order of reads; the sequencer steps through these in sequence.
  typedef enum logic [2:0] {
    FW_MAGIC, FW_DEST, FW_SRC, FW_LEN, FW_TAIL
  } fetch_slot_e;

  // Byte offset of a header word. Descriptor n sits at 8*n (source) and 8*n+4 (size).
  function automatic logic [7:0] slot_offset(fetch_slot_e slot, logic [2:0] sel);
    case (slot)
      FW_MAGIC: slot_offset = 8'h00;
      FW_DEST:  slot_offset = 8'h04;
      FW_SRC:   slot_offset = {2'b00, sel, 3'b000};
      FW_LEN:   slot_offset = {2'b00, sel, 3'b100};
      default:  slot_offset = 8'hFC;
    endcase
  endfunction

endpackage

// File: rtl/boot_hdr_blink.sv
module boot_hdr_blink #(
  parameter int HALF_CYC = 1_000_000,
  parameter int BLINKS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic led_o,
  output logic done_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int TW = $clog2(2 * BLINKS + 1);

  logic [CW-1:0] cnt_q;
  logic [TW-1:0] toggles_q;
  logic          phase_q;
  logic          half_end;

  assign half_end = (cnt_q == CW'(HALF_CYC - 1));
  assign done_o   = (toggles_q == TW'(2 * BLINKS));
  assign led_o    = en_i && !done_o && !phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      cnt_q     <= '0;
      toggles_q <= '0;
      phase_q   <= 1'b0;
    end else if (!done_o) begin
      if (half_end) begin
        cnt_q     <= '0;
        phase_q   <= ~phase_q;
        toggles_q <= toggles_q + TW'(1);
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  AST_LED_DARK_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !led_o); // R9
  AST_TOGGLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (toggles_q <= TW'(2 * BLINKS))); // R9

endmodule

// File: rtl/boot_hdr_seq.sv
module boot_hdr_seq
  import boot_hdr_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [31:0]       rd_data_i,
  input  logic              blink_done_i,
  output logic              fault_o,
  output logic              uart_boot_o,
  output logic              hdr_valid_o,
  output logic [31:0]       dest_o,
  output logic [31:0]       src_o,
  output logic [31:0]       len_o,
  output logic [15:0]       mask_o,
  output logic [15:0]       ver_o,
  output logic              hib_o
);
  boot_st_e    st_q, st_d;
  fetch_slot_e slot_q;
  logic [2:0]  sel_q;
  logic        take;
  logic        magic_hit;

  assign take      = (st_q == ST_FETCH) && rd_ack_i;
  assign magic_hit = (rd_data_i == HDR_MAGIC);

  assign rd_req_o    = (st_q == ST_FETCH);
  assign rd_addr_o   = FLASH_BASE + {{(ADDR_W-8){1'b0}}, slot_offset(slot_q, sel_q)};
  assign uart_boot_o = (st_q == ST_SERIAL);
  assign hdr_valid_o = (st_q == ST_ANNOUNCE);
  assign fault_o     = (st_q == ST_BLINK);
  assign hib_o       = (st_q == ST_SLEEP);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_START:    st_d = (strap_i == 3'b000) ? ST_SERIAL : ST_FETCH;
      ST_FETCH: begin
        if (take) begin
          if (slot_q == FW_MAGIC && !magic_hit) st_d = ST_BLINK;
          else if (slot_q == FW_TAIL)           st_d = ST_ANNOUNCE;
        end
      end
      ST_ANNOUNCE: st_d = ST_HANDOFF;
      ST_BLINK:    if (blink_done_i) st_d = ST_SLEEP;
      default:     st_d = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_START;
      slot_q <= FW_MAGIC;
      sel_q  <= 3'b000;
      dest_o <= '0;
      src_o  <= '0;
      len_o  <= '0;
      mask_o <= '0;
      ver_o  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_START) sel_q <= strap_i;
      if (take) begin
        case (slot_q)
          FW_DEST: dest_o <= rd_data_i;
          FW_SRC:  src_o  <= rd_data_i;
          FW_LEN:  len_o  <= rd_data_i;
          FW_TAIL: begin
            mask_o <= rd_data_i[31:16];
            ver_o  <= rd_data_i[15:0];
          end
          default: ;
        endcase
        if (slot_q != FW_TAIL) slot_q <= fetch_slot_e'(slot_q + 3'd1);
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o))); // R6
  AST_SERIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    uart_boot_o |-> !rd_req_o); // R2
  AST_ANNOUNCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid_o |=> !hdr_valid_o); // R7
  AST_SLEEP_AFTER_BLINK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hib_o) |-> $past(blink_done_i)); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({uart_boot_o, hdr_valid_o, hib_o, rd_req_o})); // R10
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_START) |=> $stable(sel_q)); // R3
  AST_HIB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hib_o |=> hib_o); // R9

endmodule

// File: rtl/boot_hdr_parse.sv
module boot_hdr_parse #(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'h0200_0000,
  parameter int                BLINK_HALF  = 1_000_000,
  parameter int                BLINK_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [31:0]       rd_data_i,
  output logic              uart_boot_o,
  output logic              hdr_valid_o,
  output logic [31:0]       dest_o,
  output logic [31:0]       src_o,
  output logic [31:0]       len_o,
  output logic [15:0]       mask_o,
  output logic [15:0]       ver_o,
  output logic              led_o,
  output logic              hib_o
);
  logic fault_active;
  logic blink_done;

  boot_hdr_seq #(
    .ADDR_W     (ADDR_W),
    .FLASH_BASE (FLASH_BASE)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_i      (strap_i),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .rd_ack_i     (rd_ack_i),
    .rd_data_i    (rd_data_i),
    .blink_done_i (blink_done),
    .fault_o      (fault_active),
    .uart_boot_o  (uart_boot_o),
    .hdr_valid_o  (hdr_valid_o),
    .dest_o       (dest_o),
    .src_o        (src_o),
    .len_o        (len_o),
    .mask_o       (mask_o),
    .ver_o        (ver_o),
    .hib_o        (hib_o)
  );

  boot_hdr_blink #(
    .HALF_CYC (BLINK_HALF),
    .BLINKS   (BLINK_COUNT)
  ) blink_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (fault_active),
    .led_o  (led_o),
    .done_o (blink_done)
  );

  AST_LED_ONLY_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    led_o |-> (!hdr_valid_o && !uart_boot_o && !rd_req_o)); // R10

endmodule

// File: tb/boot_hdr_parse_tb_top.sv
module boot_hdr_parse_tb_top;
  localparam int          HALF   = 3;
  localparam int          BLINKS = 2;
  localparam logic [31:0] BASE   = 32'h0200_0000;
  localparam logic [31:0] SIG    = 32'h4152_4348;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  strap = 3'b000;
  logic        rd_req, rd_ack = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic        uart_boot, hdr_valid, led, hib;
  logic [31:0] dest, src, len;
  logic [15:0] mask, ver;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  boot_hdr_parse #(
    .ADDR_W(32), .FLASH_BASE(BASE), .BLINK_HALF(HALF), .BLINK_COUNT(BLINKS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_i(strap),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .uart_boot_o(uart_boot), .hdr_valid_o(hdr_valid),
    .dest_o(dest), .src_o(src), .len_o(len), .mask_o(mask), .ver_o(ver),
    .led_o(led), .hib_o(hib)
  );

  // Flash model
  logic [31:0] mem [64];
  logic [31:0] rlog [8];
  int nread = 0;
  int lat   = 0;
  int wcnt  = 0;

  function automatic logic [31:0] src_of(int n);
    return 32'h0200_0100 + (n << 12);
  endfunction
  function automatic logic [31:0] len_of(int n);
    return 32'h0000_2224 + n * 16;
  endfunction

  always @(posedge clk) begin
    if (rd_ack) begin
      rd_ack <= 1'b0;
      wcnt   <= 0;
    end else if (rd_req) begin
      if (wcnt >= lat) begin
        rd_ack  <= 1'b1;
        rd_data <= mem[(rd_addr - BASE) >> 2];
        if (nread < 8) rlog[nread] <= rd_addr;
        nread   <= nread + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill(input bit good);
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | i;
    mem[0] = good ? SIG : (SIG ^ 32'h1);
    mem[1] = 32'h0900_0000;
    for (int n = 1; n < 8; n++) begin
      mem[2*n]   = src_of(n);
      mem[2*n+1] = len_of(n);
    end
    mem[63] = 32'h5A5A_0116;
  endtask

  task automatic run_case(input logic [2:0] s, input bit good, input int l, input bit swap);
    int led_hi = 0, rises = 0, vlen = 0, ack_c = -10, vcyc = -1, hib_c = -1, led_first = -1;
    bit prev_led = 0, prev_req = 0, prev_ack = 0, hold_ok = 1, lat_ok = 0, uart0 = 0;
    logic [31:0] prev_addr = '0, v_dest = '0, v_src = '0, v_len = '0;
    logic [15:0] v_mask = '0, v_ver = '0;
    fill(good);
    lat = l;
    rst_n = 1'b0;
    strap = s;
    repeat (3) @(negedge clk);
    nread = 0;
    rst_n = 1'b1;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (swap && c == 2) strap = (s == 3'd5) ? 3'd2 : 3'd5;
      if (c == 0) uart0 = uart_boot;
      if (prev_req && !prev_ack && !(rd_req && rd_addr == prev_addr)) hold_ok = 0;
      if (rd_ack) ack_c = c;
      if (hdr_valid) begin
        if (vcyc < 0) begin
          vcyc = c; lat_ok = (ack_c == c - 1);
          v_dest = dest; v_src = src; v_len = len; v_mask = mask; v_ver = ver;
        end
        vlen++;
      end
      if (led && !prev_led) rises++;
      if (led) begin led_hi++; if (led_first < 0) led_first = c; end
      if (hib && hib_c < 0) hib_c = c;
      prev_led = led; prev_req = rd_req; prev_ack = rd_ack; prev_addr = rd_addr;
    end
    if (s == 3'b000) begin
      chk(uart0 && uart_boot, "R2 serial boot level", {31'b0, uart_boot}, 32'h1);
      chk(nread == 0, "R2 no flash read", nread, 0);
      chk(vcyc < 0 && !hib && led_hi == 0, "R10 single outcome", vcyc, 32'hFFFF_FFFF);
    end else if (good) begin
      chk(nread == 5, "R5 read count", nread, 5);
      chk(rlog[0] == BASE && rlog[1] == BASE + 4, "R5 header reads", rlog[1], BASE + 4);
      chk(rlog[2] == BASE + 8*s && rlog[3] == BASE + 8*s + 4, "R5 descriptor reads", rlog[2], BASE + 8*s);
      chk(rlog[4] == BASE + 32'hFC, "R5 tail read", rlog[4], BASE + 32'hFC);
      chk(hold_ok, "R6 request held stable", {31'b0, hold_ok}, 32'h1);
      chk(vlen == 1, "R7 strobe width", vlen, 1);
      chk(lat_ok, "R7 strobe timing", vcyc, ack_c + 1);
      chk(v_dest == 32'h0900_0000, "R7 dest", v_dest, 32'h0900_0000);
      chk(v_src == src_of(s), "R7 src", v_src, src_of(s));
      chk(v_len == len_of(s), "R7 len", v_len, len_of(s));
      chk(v_mask == 16'h5A5A && v_ver == 16'h0116, "R8 mask/version", {v_mask, v_ver}, 32'h5A5A_0116);
      chk(!uart_boot && !hib && led_hi == 0, "R10 single outcome", {29'b0, uart_boot, hib, led}, 0);
    end else begin
      chk(nread == 1 && rlog[0] == BASE, "R4 stop after bad magic", nread, 1);
      chk(vcyc < 0, "R4 no strobe", vcyc, 32'hFFFF_FFFF);
      chk(rises == BLINKS, "R9 blink count", rises, BLINKS);
      chk(led_hi == BLINKS * HALF, "R9 led high cycles", led_hi, BLINKS * HALF);
      chk(led_first == ack_c + 1, "R9 first blink timing", led_first, ack_c + 1);
      chk(hib_c == led_first + 2*BLINKS*HALF + 1, "R9 hibernate timing", hib_c, led_first + 2*BLINKS*HALF + 1);
      chk(hib && !led && !uart_boot, "R9 hibernate held", {30'b0, hib, led}, 32'h2);
    end
  endtask

  // {strap, good, latency}
  localparam logic [5:0] VEC [11] = '{
    {3'd0, 1'b1, 2'd1}, {3'd1, 1'b1, 2'd0}, {3'd2, 1'b1, 2'd2}, {3'd3, 1'b1, 2'd1},
    {3'd4, 1'b1, 2'd0}, {3'd5, 1'b1, 2'd3}, {3'd6, 1'b1, 2'd1}, {3'd7, 1'b1, 2'd2},
    {3'd3, 1'b0, 2'd1}, {3'd6, 1'b0, 2'd0}, {3'd0, 1'b0, 2'd0}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    fill(1'b1);
    // R1: reset state with a flash strap and with the serial strap
    strap = 3'd4;
    repeat (4) @(negedge clk);
    chk({rd_req, uart_boot, hdr_valid, led, hib} == 5'b0, "R1 reset outputs",
        {27'b0, rd_req, uart_boot, hdr_valid, led, hib}, 0);
    strap = 3'd0;
    @(negedge clk);
    chk({rd_req, uart_boot, hdr_valid, led, hib} == 5'b0, "R1 reset outputs serial strap",
        {27'b0, rd_req, uart_boot, hdr_valid, led, hib}, 0);

    for (int i = 0; i < 11; i++)
      run_case(VEC[i][5:3], VEC[i][2], int'(VEC[i][1:0]), 1'b0);

    // R3: strap changes after latching are ignored (strap 5 then 2, and strap 2 then 5)
    run_case(3'd5, 1'b1, 2, 1'b1);
    chk(src == src_of(5) && len == len_of(5), "R3 strap latched once", src, src_of(5));
    run_case(3'd2, 1'b1, 0, 1'b1);
    chk(src == src_of(2) && rlog[2] == BASE + 16, "R3 strap latched once", rlog[2], BASE + 16);

    // R1: reset mid-fault clears outputs
    fill(1'b0);
    rst_n = 1'b0; strap = 3'd1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk({rd_req, uart_boot, hdr_valid, led, hib} == 5'b0, "R1 reset during fault",
        {27'b0, rd_req, uart_boot, hdr_valid, led, hib}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule